// File: doc/BRIEF.md
# Mute Pin and General-Purpose Output Controller

This block produces the external mute control pin and seven general-purpose output pins of an audio converter. The mute pin is released (output enable low) while the converter is powered down. Once powered up, it is driven to a programmable active level whenever a soft reset is in progress, the clock ratio is wrong, software forces it, or every DAC channel has been carrying silence for a long run of samples.

Each general-purpose pin has its own 4-bit function code. The code selects one of the following sources:
- a fixed low or high level;
- the mute state of one DAC channel, meaning its software mute bit or its own silence detection;
- a sticky overflow indication from the left or right ADC, which holds until software clears it.

Silence detection counts consecutive all-zero samples on each channel. One sample is counted on each sample strobe. Every pin leaves through exactly one register stage clocked by the system clock.

Top module: `mgc_mute_gpo`

## Requirements
- R1: `mute_oe_o` is 0 from reset and in the cycle after any cycle with `pdn_i` high. It is 1 in the cycle after any cycle with `pdn_i` low.
- R2: With `pdn_i` low, `mute_o` takes the asserted level in the next cycle while `soft_rst_i`, `ratio_err_i` or `mute_force_i` is high. The asserted level equals `mute_pol_i` (1 = active high, 0 = active low). With no mute cause, `mute_o` takes the opposite level.
- R3: A DAC channel counts as silent once 8192 consecutive sample strobes (`smp_valid_i` high) have seen its `dac_zero_i` bit high. A strobe with the bit low restarts the count. Cycles without a strobe neither count nor clear.
- R4: The mute pin is asserted when all six channels are silent. It is not asserted when at least one channel is not silent.
- R5: The mute of DAC channel c is `dac_mute_i[c]` OR the silence of channel c.
- R6: The function code of pin k is `gpo_func_i[4k+3:4k]`. Code 0 drives low, code 1 drives high, and codes 10 to 15 drive low.
- R7: Codes 2 to 7 make the pin follow the mute of DAC channel 0 to 5 (channel = code - 2).
- R8: Code 8 follows the left ADC overflow (`adc_ovf_i[0]`) and code 9 follows the right ADC overflow (`adc_ovf_i[1]`). An overflow indication holds until a cycle with `ovf_clr_i` high. An overflow in the same cycle as the clear still sets the indication.
- R9: Every output changes exactly one clock edge after the input that causes it. Silence detection adds its own counter stage.
- R10: While powered down, `mute_o` is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdn_i | input | 1 | Power-down request |
| soft_rst_i | input | 1 | Converter soft reset in progress |
| ratio_err_i | input | 1 | Master-clock to frame-clock ratio is wrong |
| mute_force_i | input | 1 | Software mute request for the mute pin |
| mute_pol_i | input | 1 | Asserted level of the mute pin |
| dac_mute_i | input | 6 | Per-channel software mute bits |
| smp_valid_i | input | 1 | One strobe per audio sample period |
| dac_zero_i | input | 6 | Per-channel flag: current sample is all zero |
| adc_ovf_i | input | 2 | ADC overflow, bit 0 left, bit 1 right |
| ovf_clr_i | input | 1 | Clears held overflow indications |
| gpo_func_i | input | 28 | Seven 4-bit function codes, pin k at bits 4k+3:4k |
| mute_o | output | 1 | Mute pin level |
| mute_oe_o | output | 1 | Mute pin output enable (0 = high impedance) |
| gpo_o | output | 7 | General-purpose pin levels |

## Verification
A silence counter stuck or off by one shows up as a mute pin that asserts one strobe early or late at the 8192-sample boundary. It also shows up as a channel-mapped pin that fails to drop one cycle after a nonzero sample. A lost overflow hold drops a code-8 or code-9 pin within one cycle of the overflow pulse ending. A wrong code decode shows up one cycle after the code is written. An output-enable state that does not follow power-down exposes the pin during power-down within a single edge.

// File: rtl/mgc_pkg.sv
package mgc_pkg;
  localparam int unsigned FUNC_W   = 4;
  localparam int unsigned FN_LOW   = 0;
  localparam int unsigned FN_HIGH  = 1;
  localparam int unsigned FN_MUTE0 = 2;
endpackage

// File: rtl/mgc_zero_run.sv
module mgc_zero_run #(
  parameter int unsigned RUN_LEN = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic zero_i,
  output logic det_o
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_i) begin
      if (!zero_i) cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign det_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/mgc_ovf_hold.sv
module mgc_ovf_hold #(
  parameter int unsigned NUM_ADC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ADC-1:0] ovf_i,
  input  logic               clr_i,
  output logic [NUM_ADC-1:0] held_o
);
  logic [NUM_ADC-1:0] sticky_q;

  // new overflow wins over a clear in the same cycle
  assign held_o = ovf_i | (sticky_q & {NUM_ADC{~clr_i}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= held_o;
  end
endmodule

// File: rtl/mgc_gpo_sel.sv
module mgc_gpo_sel
  import mgc_pkg::*;
#(
  parameter int unsigned NUM_DAC = 6,
  parameter int unsigned NUM_ADC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FUNC_W-1:0]  func_i,
  input  logic [NUM_DAC-1:0] ch_mute_i,
  input  logic [NUM_ADC-1:0] ovf_held_i,
  output logic               gpo_o
);
  localparam int unsigned OVF0 = FN_MUTE0 + NUM_DAC;

  logic sel;
  logic gpo_q;

  always_comb begin
    sel = 1'b0;
    if (func_i == FUNC_W'(FN_HIGH)) sel = 1'b1;
    for (int c = 0; c < NUM_DAC; c++)
      if (func_i == FUNC_W'(FN_MUTE0 + c)) sel = ch_mute_i[c];
    for (int a = 0; a < NUM_ADC; a++)
      if (func_i == FUNC_W'(OVF0 + a)) sel = ovf_held_i[a];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gpo_q <= 1'b0;
    else         gpo_q <= sel;
  end

  assign gpo_o = gpo_q;
endmodule

// File: rtl/mgc_mute_drv.sv
module mgc_mute_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_i,
  input  logic soft_rst_i,
  input  logic ratio_err_i,
  input  logic force_i,
  input  logic all_zero_i,
  input  logic pol_i,
  output logic mute_o,
  output logic oe_o
);
  logic active;
  logic mute_q, oe_q;

  assign active = soft_rst_i | ratio_err_i | force_i | all_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q   <= ~pdn_i;
      mute_q <= pdn_i ? 1'b0 : (active ? pol_i : ~pol_i);
    end
  end

  assign mute_o = mute_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/mgc_mute_gpo.sv
module mgc_mute_gpo
  import mgc_pkg::*;
#(
  parameter int unsigned NUM_DAC = 6,
  parameter int unsigned NUM_ADC = 2,
  parameter int unsigned NUM_GPO = 7,
  parameter int unsigned RUN_LEN = 8192
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pdn_i,
  input  logic                      soft_rst_i,
  input  logic                      ratio_err_i,
  input  logic                      mute_force_i,
  input  logic                      mute_pol_i,
  input  logic [NUM_DAC-1:0]        dac_mute_i,
  input  logic                      smp_valid_i,
  input  logic [NUM_DAC-1:0]        dac_zero_i,
  input  logic [NUM_ADC-1:0]        adc_ovf_i,
  input  logic                      ovf_clr_i,
  input  logic [NUM_GPO*FUNC_W-1:0] gpo_func_i,
  output logic                      mute_o,
  output logic                      mute_oe_o,
  output logic [NUM_GPO-1:0]        gpo_o
);
  logic [NUM_DAC-1:0] zero_det;
  logic [NUM_DAC-1:0] ch_mute;
  logic [NUM_ADC-1:0] ovf_held;
  logic               all_zero;

  for (genvar c = 0; c < NUM_DAC; c++) begin : g_zero
    mgc_zero_run #(.RUN_LEN(RUN_LEN)) u_run (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(smp_valid_i),
      .zero_i (dac_zero_i[c]),
      .det_o  (zero_det[c])
    );
  end

  assign ch_mute  = dac_mute_i | zero_det;
  assign all_zero = &zero_det;

  mgc_ovf_hold #(.NUM_ADC(NUM_ADC)) u_ovf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ovf_i (adc_ovf_i),
    .clr_i (ovf_clr_i),
    .held_o(ovf_held)
  );

  mgc_mute_drv u_mute (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pdn_i      (pdn_i),
    .soft_rst_i (soft_rst_i),
    .ratio_err_i(ratio_err_i),
    .force_i    (mute_force_i),
    .all_zero_i (all_zero),
    .pol_i      (mute_pol_i),
    .mute_o     (mute_o),
    .oe_o       (mute_oe_o)
  );

  for (genvar k = 0; k < NUM_GPO; k++) begin : g_gpo
    mgc_gpo_sel #(.NUM_DAC(NUM_DAC), .NUM_ADC(NUM_ADC)) u_sel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .func_i    (gpo_func_i[k*FUNC_W +: FUNC_W]),
      .ch_mute_i (ch_mute),
      .ovf_held_i(ovf_held),
      .gpo_o     (gpo_o[k])
    );
  end
endmodule

// File: rtl/mgc_mute_gpo_chk.sv
module mgc_mute_gpo_chk #(
  parameter int unsigned NUM_DAC = 6,
  parameter int unsigned NUM_GPO = 7,
  parameter int unsigned FUNC_W  = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      pdn_i,
  input logic                      soft_rst_i,
  input logic                      ratio_err_i,
  input logic                      mute_force_i,
  input logic                      mute_pol_i,
  input logic                      all_zero_i,
  input logic                      ovf_clr_i,
  input logic [NUM_GPO*FUNC_W-1:0] gpo_func_i,
  input logic                      mute_o,
  input logic                      mute_oe_o,
  input logic [NUM_GPO-1:0]        gpo_o
);
  localparam logic [FUNC_W-1:0] OVF_L = FUNC_W'(2 + NUM_DAC);

  // R1
  pdn_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> !mute_oe_o);
  // R1
  pup_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_i |=> mute_oe_o);
  // R10
  pdn_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> !mute_o);
  // R2
  src_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_i && (soft_rst_i || ratio_err_i || mute_force_i)) |=> (mute_o == $past(mute_pol_i)));
  // R2
  quiet_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_i && !soft_rst_i && !ratio_err_i && !mute_force_i && !all_zero_i)
      |=> (mute_o == !$past(mute_pol_i)));
  // R4
  all_zero_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_i && all_zero_i) |=> (mute_o == $past(mute_pol_i)));

  for (genvar k = 0; k < NUM_GPO; k++) begin : g_pin
    // R6
    low_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gpo_func_i[k*FUNC_W +: FUNC_W] == '0) |=> !gpo_o[k]);
    // R6
    high_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gpo_func_i[k*FUNC_W +: FUNC_W] == FUNC_W'(1)) |=> gpo_o[k]);
    // R8
    ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gpo_o[k] && !ovf_clr_i && gpo_func_i[k*FUNC_W +: FUNC_W] == OVF_L
       && $past(gpo_func_i[k*FUNC_W +: FUNC_W]) == OVF_L) |=> gpo_o[k]);
  end
endmodule

bind mgc_mute_gpo mgc_mute_gpo_chk #(
  .NUM_DAC(NUM_DAC), .NUM_GPO(NUM_GPO), .FUNC_W(mgc_pkg::FUNC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pdn_i       (pdn_i),
  .soft_rst_i  (soft_rst_i),
  .ratio_err_i (ratio_err_i),
  .mute_force_i(mute_force_i),
  .mute_pol_i  (mute_pol_i),
  .all_zero_i  (all_zero),
  .ovf_clr_i   (ovf_clr_i),
  .gpo_func_i  (gpo_func_i),
  .mute_o      (mute_o),
  .mute_oe_o   (mute_oe_o),
  .gpo_o       (gpo_o)
);

// File: tb/mgc_mute_gpo_bench.sv
module mgc_mute_gpo_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pdn_i = 1'b1;
  logic        soft_rst_i = 1'b0, ratio_err_i = 1'b0, mute_force_i = 1'b0;
  logic        mute_pol_i = 1'b1;
  logic [5:0]  dac_mute_i = '0;
  logic        smp_valid_i = 1'b0;
  logic [5:0]  dac_zero_i = '0;
  logic [1:0]  adc_ovf_i = '0;
  logic        ovf_clr_i = 1'b0;
  logic [27:0] gpo_func_i = '0;
  logic        mute_o, mute_oe_o;
  logic [6:0]  gpo_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  mgc_mute_gpo u_mgc_mute_gpo (
    .clk_i(clk_i), .rst_ni(rst_ni), .pdn_i(pdn_i), .soft_rst_i(soft_rst_i),
    .ratio_err_i(ratio_err_i), .mute_force_i(mute_force_i), .mute_pol_i(mute_pol_i),
    .dac_mute_i(dac_mute_i), .smp_valid_i(smp_valid_i), .dac_zero_i(dac_zero_i),
    .adc_ovf_i(adc_ovf_i), .ovf_clr_i(ovf_clr_i), .gpo_func_i(gpo_func_i),
    .mute_o(mute_o), .mute_oe_o(mute_oe_o), .gpo_o(gpo_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_func(input int pin, input int code);
    gpo_func_i[pin*4 +: 4] = 4'(code);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 oe in reset", int'(mute_oe_o), 0);
    chk("R10 mute in reset", int'(mute_o), 0);
    chk("R9 gpo in reset", int'(gpo_o), 0);
    rst_ni = 1'b1;
    step(2);
    chk("R1 oe powered down", int'(mute_oe_o), 0);
  endtask

  task automatic t_power();
    mute_pol_i = 1'b1;
    pdn_i = 1'b0;
    chk("R9 oe before edge", int'(mute_oe_o), 0);
    step(1);
    chk("R1 oe after power-up", int'(mute_oe_o), 1);
    chk("R2 quiet level pol1", int'(mute_o), 0);
    mute_pol_i = 1'b0;
    step(1);
    chk("R2 quiet level pol0", int'(mute_o), 1);
    mute_force_i = 1'b1;
    pdn_i = 1'b1;
    step(1);
    chk("R1 oe back in power-down", int'(mute_oe_o), 0);
    chk("R10 mute low in power-down", int'(mute_o), 0);
    mute_force_i = 1'b0;
    pdn_i = 1'b0;
    step(1);
  endtask

  task automatic t_sources();
    for (int pol = 0; pol < 2; pol++) begin
      for (int s = 0; s < 3; s++) begin
        mute_pol_i = 1'(pol);
        soft_rst_i = (s == 0);
        ratio_err_i = (s == 1);
        mute_force_i = (s == 2);
        step(1);
        chk($sformatf("R2 source %0d pol %0d asserted", s, pol), int'(mute_o), pol);
        soft_rst_i = 1'b0; ratio_err_i = 1'b0; mute_force_i = 1'b0;
        step(1);
        chk($sformatf("R2 source %0d pol %0d released", s, pol), int'(mute_o), 1 - pol);
      end
    end
    mute_pol_i = 1'b1;
  endtask

  task automatic t_zero();
    set_func(0, 2);
    set_func(1, 3);
    smp_valid_i = 1'b1; dac_zero_i = '0;
    step(1);
    dac_zero_i = 6'h3f;
    step(8191);
    smp_valid_i = 1'b0;
    step(1);
    chk("R3 no mute after 8191 zero samples", int'(mute_o), 0);
    chk("R7 ch0 pin before run end", int'(gpo_o[0]), 0);
    dac_zero_i = '0;
    step(4);
    chk("R3 no strobe keeps quiet", int'(mute_o), 0);
    smp_valid_i = 1'b1; dac_zero_i = 6'h3f;
    step(1);
    smp_valid_i = 1'b0;
    chk("R9 counter stage before mute", int'(mute_o), 0);
    step(1);
    chk("R4 mute after 8192 zero samples on all", int'(mute_o), 1);
    chk("R5 ch0 silent mute on pin", int'(gpo_o[0]), 1);
    chk("R5 ch1 silent mute on pin", int'(gpo_o[1]), 1);
    smp_valid_i = 1'b1; dac_zero_i = 6'h3e;
    step(1);
    smp_valid_i = 1'b0;
    step(1);
    chk("R3 nonzero sample clears mute", int'(mute_o), 0);
    chk("R3 ch0 pin drops", int'(gpo_o[0]), 0);
    chk("R3 ch1 pin stays", int'(gpo_o[1]), 1);
    smp_valid_i = 1'b1; dac_zero_i = 6'h1f;
    step(1);
    smp_valid_i = 1'b0;
    step(1);
    chk("R4 five silent channels no mute", int'(mute_o), 0);
    chk("R4 ch1 still silent", int'(gpo_o[1]), 1);
    smp_valid_i = 1'b1; dac_zero_i = '0;
    step(1);
    smp_valid_i = 1'b0;
    step(1);
    chk("R3 all counters cleared", int'(gpo_o[1:0]), 0);
  endtask

  task automatic t_gpo();
    set_func(0, 0); set_func(1, 1); set_func(2, 10); set_func(3, 15);
    step(1);
    chk("R6 static codes 0 1 10 15", int'(gpo_o[3:0]), 2);
    for (int c = 0; c < 6; c++) set_func(c, 2 + c);
    set_func(6, 1);
    dac_mute_i = 6'b100101;
    chk("R9 pins before edge", int'(gpo_o[0]), 0);
    step(1);
    chk("R7 mute map", int'(gpo_o), 7'b1100101);
    dac_mute_i = 6'b011010;
    step(1);
    chk("R7 mute map inverted", int'(gpo_o), 7'b1011010);
    dac_mute_i = '0;
  endtask

  task automatic t_ovf();
    gpo_func_i = '0;
    set_func(0, 8); set_func(1, 9);
    step(1);
    adc_ovf_i = 2'b01;
    step(1);
    adc_ovf_i = 2'b00;
    chk("R8 left overflow shown", int'(gpo_o[1:0]), 1);
    step(3);
    chk("R8 left overflow held", int'(gpo_o[1:0]), 1);
    ovf_clr_i = 1'b1;
    step(1);
    ovf_clr_i = 1'b0;
    chk("R8 cleared", int'(gpo_o[1:0]), 0);
    adc_ovf_i = 2'b10; ovf_clr_i = 1'b1;
    step(1);
    adc_ovf_i = 2'b00; ovf_clr_i = 1'b0;
    step(2);
    chk("R8 overflow with clear still held", int'(gpo_o[1:0]), 2);
    ovf_clr_i = 1'b1;
    step(1);
    ovf_clr_i = 1'b0;
    chk("R8 right cleared", int'(gpo_o[1:0]), 0);
  endtask

  initial begin
    t_reset();
    t_power();
    t_sources();
    t_zero();
    t_gpo();
    t_ovf();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule